// File: doc/BRIEF.md
# Dual-Bank BCD Calendar Register File

This block keeps time of day and calendar date in packed BCD and presents it through a small byte-wide register page. It holds two banks. A running bank of counters advances on a one-cycle `tick_i` pulse, once per second. A user bank is what the register port reads and writes. The user bank takes a full snapshot of the running bank in the clock cycle after each tick, with every field changing on the same edge.

Software freezes the user view by setting a read-halt control bit. The running counters keep counting while the view is frozen, so no time is lost. To set the clock, software sets a write-halt bit, writes the new values into the user bank, and then clears the bit. The edge that clears the bit copies the user bank into the running counters. A stop bit held in the seconds register freezes the running counters. The control register also holds six bits of calibration storage. A flags register reports a battery-low status input. The oscillator divider, the memory array and the supply sensing are outside this block and only drive `tick_i` and `batt_low_i`.

Top module: `bcd_cal_regs`

## Requirements
- R1: The register page is selected only when every address bit above bit 3 is 1. When the page is not selected, `rdata_o` reads 0x00 and writes change nothing. Offsets within the page:
  - 0x0: flags
  - 0x1: century
  - 0x8: control
  - 0x9 to 0xF: seconds, minutes, hours, day of week, date, month and year, in that order
- R2: Seconds and minutes count 00 to 59 and then wrap to 00, carrying into the next field. Hours count 00 to 23 and wrap to 00, carrying into both the day and date fields.
- R3: The last date of a month is:
  - 31 for months 01, 03, 05, 07, 08, 10 and 12
  - 30 for months 04, 06, 09 and 11
  - 29 for month 02 when the year is divisible by 4, including year 00, and 28 otherwise

  Month 12 wraps to 01 and increments the year.
- R4: While control bit 6 (read halt) is 1, the user bank does not follow the counters, but the counters keep advancing. The first copy after the bit clears shows the elapsed time.
- R5: Writing control with bit 7 at 0 while bit 7 was 1 loads all eight user time fields into the running counters on that edge. A tick on the same edge is dropped, and later ticks advance from the loaded values.
- R6: The user bank refreshes in the cycle after a tick, not the cycle of the tick. A halt bit written on the refresh cycle does not block that refresh.
- R7: Seconds bit 7 is a stop bit that can be written without the write halt. While it is 1, ticks do not advance the counters. Once it is cleared, the next tick advances again.
- R8: After reset:
  - control reads 0x00 and the stop bit is 0
  - the time fields read 00:00:00
  - day reads 1, date 01, month 01, year 00 and century 20
- R9: Control bits 5 to 0 are plain storage and read back as written.
- R10: Flags bit 4 reads the level of `batt_low_i`. All other flags bits read 0, and writes to flags have no effect.
- R11: Year 99 wraps to 00 and increments the century in BCD, and century 99 wraps to 00. Day of week counts 1 to 7 and wraps to 1 each time the date advances.
- R12: Unused bit positions read 0 and ignore writes. Stored widths are:
  - seconds and minutes: 7 bits
  - hours and date: 6 bits
  - month: 5 bits
  - day: 3 bits

  Offsets 0x2 to 0x7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address; the top 16 bytes form the register page |
| wr_en_i | input | 1 | Write strobe for the current address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current address, combinational |
| tick_i | input | 1 | One-cycle pulse, once per second |
| batt_low_i | input | 1 | Battery-low status shown in the flags register |

## Verification
A tick sampled on edge N updates the running counters on edge N. The user bank copies them on edge N+1, so a read taken on the low phase after edge N still shows the old time, and a read after edge N+1 shows the new time. Register writes, and a counter load caused by clearing the write halt, take effect on the edge that samples the strobe. Reads are combinational from the user bank. Inputs are driven on the falling edge and outputs are sampled 1 ns later, so every expected value is compared at a fixed point between two rising edges. Expected calendars come from a bench model that steps a plain integer date by one second per tick.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int NF     = 8;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  typedef logic [NF-1:0][7:0] fld_vec_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // field whose wrap feeds field i
  function automatic int carry_src(input int i);
    case (i)
      F_MIN:  carry_src = F_SEC;
      F_HOUR: carry_src = F_MIN;
      F_DAY:  carry_src = F_HOUR;
      F_DATE: carry_src = F_HOUR;
      F_MON:  carry_src = F_DATE;
      F_YEAR: carry_src = F_MON;
      F_CENT: carry_src = F_YEAR;
      default: carry_src = F_SEC;
    endcase
  endfunction

  function automatic logic [7:0] fld_lo(input int i);
    fld_lo = (i == F_DAY || i == F_DATE || i == F_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] fld_hi(input int i);
    case (i)
      F_SEC, F_MIN: fld_hi = 8'h59;
      F_HOUR:       fld_hi = 8'h23;
      F_DAY:        fld_hi = 8'h07;
      F_DATE:       fld_hi = 8'h31;
      F_MON:        fld_hi = 8'h12;
      default:      fld_hi = 8'h99;
    endcase
  endfunction

  function automatic logic [7:0] fld_mask(input int i);
    case (i)
      F_SEC, F_MIN:   fld_mask = 8'h7f;
      F_HOUR, F_DATE: fld_mask = 8'h3f;
      F_DAY:          fld_mask = 8'h07;
      F_MON:          fld_mask = 8'h1f;
      default:        fld_mask = 8'hff;
    endcase
  endfunction

  function automatic logic [7:0] fld_rst(input int i);
    fld_rst = (i == F_CENT) ? 8'h20 : fld_lo(i);
  endfunction

  // year in BCD divisible by 4
  function automatic logic leap_bcd(input logic [7:0] yr);
    logic [3:0] u;
    u = yr[3:0];
    if (yr[4]) leap_bcd = (u == 4'd2) || (u == 4'd6);
    else       leap_bcd = (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      month_len = leap_bcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_len = 8'h30;
      default:                    month_len = 8'h31;
    endcase
  endfunction

  // {hit, field index} for a page offset
  function automatic logic [3:0] off_fld(input logic [3:0] off);
    if (off == 4'h1)     off_fld = {1'b1, 3'(F_CENT)};
    else if (off >= 4'h9) off_fld = {1'b1, 3'(off - 4'h9)};
    else                 off_fld = 4'h0;
  endfunction
endpackage

// File: rtl/bcd_field_ctr.sv
module bcd_field_ctr
  import bcd_cal_pkg::*;
#(
  parameter logic [7:0] LO  = 8'h00,
  parameter logic [7:0] RST = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic [7:0] hi_i,
  output logic [7:0] q_o,
  output logic       at_max_o
);
  logic [7:0] q_q;

  assign at_max_o = (q_q >= hi_i);
  assign q_o      = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= RST;
    else if (load_i) q_q <= load_val_i;
    else if (inc_i)  q_q <= at_max_o ? LO : bcd_inc(q_q);
  end
endmodule

// File: rtl/bcd_time_core.sv
module bcd_time_core
  import bcd_cal_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     adv_i,
  input  logic     load_i,
  input  fld_vec_t load_val_i,
  output fld_vec_t cnt_o
);
  logic [NF-1:0] inc_v;
  logic [NF-1:0] at_max;
  fld_vec_t      hi_v;

  always_comb begin
    inc_v[0] = adv_i;
    for (int i = 1; i < NF; i++)
      inc_v[i] = inc_v[carry_src(i)] && at_max[carry_src(i)];
  end

  for (genvar g = 0; g < NF; g++) begin : g_fld
    if (g == F_DATE) begin : g_dyn
      assign hi_v[g] = month_len(cnt_o[F_MON], cnt_o[F_YEAR]);
    end else begin : g_fix
      assign hi_v[g] = fld_hi(g);
    end

    bcd_field_ctr #(
      .LO  (fld_lo(g)),
      .RST (fld_rst(g))
    ) u_ctr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (inc_v[g]),
      .load_i     (load_i),
      .load_val_i (load_val_i[g]),
      .hi_i       (hi_v[g]),
      .q_o        (cnt_o[g]),
      .at_max_o   (at_max[g])
    );
  end
endmodule

// File: rtl/bcd_user_bank.sv
module bcd_user_bank
  import bcd_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic [3:0] off_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       tick_i,
  input  logic       batt_low_i,
  input  fld_vec_t   cnt_i,
  output fld_vec_t   usr_o,
  output logic [7:0] ctrl_o,
  output logic       stop_o,
  output logic       load_o,
  output logic [7:0] rdata_o
);
  localparam int W_BIT = 7;
  localparam int R_BIT = 6;

  logic       tick_d;
  logic       copy;
  logic       wr_page;
  logic [3:0] fsel;
  logic [7:0] ctrl_q;
  logic       stop_q;
  fld_vec_t   usr_q;

  assign wr_page = wr_i && sel_i;
  assign fsel    = off_fld(off_i);
  // halt bits as held before this edge: a halt landing now cannot cut this copy
  assign copy    = tick_d && !ctrl_q[W_BIT] && !ctrl_q[R_BIT];
  assign load_o  = wr_page && (off_i == 4'h8) && ctrl_q[W_BIT] && !wdata_i[W_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_d <= 1'b0;
    else         tick_d <= tick_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 8'h00;
      stop_q <= 1'b0;
    end else begin
      if (wr_page && off_i == 4'h8) ctrl_q <= wdata_i;
      if (wr_page && off_i == 4'h9) stop_q <= wdata_i[7];
    end
  end

  for (genvar g = 0; g < NF; g++) begin : g_usr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        usr_q[g] <= fld_rst(g);
      else if (copy)
        usr_q[g] <= cnt_i[g];
      else if (wr_page && fsel[3] && fsel[2:0] == 3'(g))
        usr_q[g] <= wdata_i & fld_mask(g);
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (sel_i) begin
      if (off_i == 4'h0)      rdata_o[4] = batt_low_i;
      else if (off_i == 4'h8) rdata_o = ctrl_q;
      else if (off_i == 4'h9) rdata_o = {stop_q, usr_q[F_SEC][6:0]};
      else if (fsel[3])       rdata_o = usr_q[fsel[2:0]];
    end
  end

  assign usr_o  = usr_q;
  assign ctrl_o = ctrl_q;
  assign stop_o = stop_q;
endmodule

// File: rtl/bcd_cal_regs.sv
module bcd_cal_regs
  import bcd_cal_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              tick_i,
  input  logic              batt_low_i
);
  localparam int OFF_W = 4;

  logic       sel;
  logic [7:0] ctrl_q;
  logic       stop_q;
  logic       load_w;
  logic       adv_w;
  fld_vec_t   usr_q;
  fld_vec_t   cnt_q;

  assign sel   = &addr_i[ADDR_W-1:OFF_W];
  assign adv_w = tick_i && !stop_q;

  bcd_user_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .off_i      (addr_i[OFF_W-1:0]),
    .wr_i       (wr_en_i),
    .wdata_i    (wdata_i),
    .tick_i     (tick_i),
    .batt_low_i (batt_low_i),
    .cnt_i      (cnt_q),
    .usr_o      (usr_q),
    .ctrl_o     (ctrl_q),
    .stop_o     (stop_q),
    .load_o     (load_w),
    .rdata_o    (rdata_o)
  );

  bcd_time_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv_w),
    .load_i     (load_w),
    .load_val_i (usr_q),
    .cnt_o      (cnt_q)
  );
endmodule

// File: rtl/bcd_cal_regs_chk.sv
module bcd_cal_regs_chk
  import bcd_cal_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [7:0]        rdata_o,
  input logic [7:0]        ctrl_q,
  input logic              stop_q,
  input logic              adv_w,
  input logic              load_w,
  input fld_vec_t          usr_q,
  input fld_vec_t          cnt_q
);
  p_sec_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_w && !load_w && cnt_q[F_SEC] == 8'h59) |=> cnt_q[F_SEC] == 8'h00);

  p_hour_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_w && !load_w && cnt_q[F_SEC] == 8'h59 && cnt_q[F_MIN] == 8'h59 && cnt_q[F_HOUR] == 8'h23)
    |=> cnt_q[F_HOUR] == 8'h00);

  p_read_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[6] && !wr_en_i) |=> $stable(usr_q));

  p_load_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q[7]) |-> (cnt_q == usr_q));

  p_stop_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !load_w) |=> $stable(cnt_q));

  p_gap_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&addr_i[ADDR_W-1:4]) && addr_i[3:0] inside {[4'h2:4'h7]}) |-> rdata_o == 8'h00);
endmodule

bind bcd_cal_regs bcd_cal_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .rdata_o (rdata_o),
  .ctrl_q  (ctrl_q),
  .stop_q  (stop_q),
  .adv_w   (adv_w),
  .load_w  (load_w),
  .usr_q   (usr_q),
  .cnt_q   (cnt_q)
);

// File: tb/bcd_cal_regs_tb_top.sv
module bcd_cal_regs_tb_top;
  localparam int ADDR_W = 19;
  localparam int CLK_PERIOD = 10;
  localparam logic [ADDR_W-5:0] PAGE = '1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        wdata = 8'h00;
  logic [7:0]        rdata;
  logic              tick = 1'b0;
  logic              batt = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model time, plain integers
  int s, mi, h, dy, dt, mo, yr, ce;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_cal_regs #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .addr_i     (addr),
    .wr_en_i    (wr_en),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .tick_i     (tick),
    .batt_low_i (batt)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    s++;
    if (s < 60) return;
    s = 0; mi++;
    if (mi < 60) return;
    mi = 0; h++;
    if (h < 24) return;
    h = 0;
    dy = (dy == 7) ? 1 : dy + 1;
    dt++;
    if (dt <= mlen(mo, yr)) return;
    dt = 1; mo++;
    if (mo <= 12) return;
    mo = 1; yr++;
    if (yr < 100) return;
    yr = 0;
    ce = (ce == 99) ? 0 : ce + 1;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk);
    addr = {PAGE, off}; wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] off, output logic [7:0] d);
    @(negedge clk);
    addr = {PAGE, off};
    #1 d = rdata;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input int ns, input int nmi, input int nh, input int ndy,
                          input int ndt, input int nmo, input int nyr, input int nce);
    s = ns; mi = nmi; h = nh; dy = ndy; dt = ndt; mo = nmo; yr = nyr; ce = nce;
    bus_wr(4'h8, 8'h80);
    bus_wr(4'h9, to_bcd(s));  bus_wr(4'hA, to_bcd(mi));
    bus_wr(4'hB, to_bcd(h));  bus_wr(4'hC, to_bcd(dy));
    bus_wr(4'hD, to_bcd(dt)); bus_wr(4'hE, to_bcd(mo));
    bus_wr(4'hF, to_bcd(yr)); bus_wr(4'h1, to_bcd(ce));
    bus_wr(4'h8, 8'h00);
  endtask

  task automatic read_all(input string tag);
    logic [7:0] d;
    bus_rd(4'h9, d); chk(tag, d, to_bcd(s));
    bus_rd(4'hA, d); chk(tag, d, to_bcd(mi));
    bus_rd(4'hB, d); chk(tag, d, to_bcd(h));
    bus_rd(4'hC, d); chk(tag, d, to_bcd(dy));
    bus_rd(4'hD, d); chk(tag, d, to_bcd(dt));
    bus_rd(4'hE, d); chk(tag, d, to_bcd(mo));
    bus_rd(4'hF, d); chk(tag, d, to_bcd(yr));
    bus_rd(4'h1, d); chk(tag, d, to_bcd(ce));
  endtask

  task automatic tick_check(input string tag);
    do_tick(); model_step(); read_all(tag);
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] s0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    s = 0; mi = 0; h = 0; dy = 1; dt = 1; mo = 1; yr = 0; ce = 20;
    read_all("R8");
    bus_rd(4'h8, d); chk("R8 ctrl", d, 8'h00);

    // R5 load then advance
    set_time(10, 20, 13, 3, 15, 6, 24, 20);
    read_all("R5 loaded");
    tick_check("R5");

    // R2 / R3 / R11 directed rollovers
    set_time(59, 59, 23, 7, 31, 12, 99, 19); tick_check("R11 century");
    set_time(59, 59, 23, 2, 31, 12, 99, 99); tick_check("R11 century wrap");
    set_time(59, 59, 23, 4, 28, 2, 24, 20);  tick_check("R3 leap 28");
    set_time(59, 59, 23, 5, 29, 2, 24, 20);  tick_check("R3 leap 29");
    set_time(59, 59, 23, 1, 28, 2, 23, 20);  tick_check("R3 common feb");
    set_time(59, 59, 23, 1, 28, 2, 0, 21);   tick_check("R3 year 00 leap");
    set_time(59, 59, 23, 3, 30, 4, 25, 20);  tick_check("R3 april");
    set_time(59, 59, 23, 3, 30, 1, 25, 20);  tick_check("R3 jan 30");
    set_time(59, 59, 22, 6, 10, 7, 25, 20);  tick_check("R2 hour");
    set_time(59, 41, 5, 6, 10, 7, 25, 20);   tick_check("R2 minute");

    // R6 copy timing and halt on the copy cycle, then R4 hold
    set_time(5, 0, 0, 1, 1, 1, 30, 20);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; addr = {PAGE, 4'h9};
    #1 chk("R6 no copy on tick cycle", rdata, 8'h05);
    #1 addr = {PAGE, 4'h8}; wr_en = 1'b1; wdata = 8'h40;
    @(negedge clk); wr_en = 1'b0;
    model_step();
    bus_rd(4'h9, d); chk("R6 copy despite halt", d, 8'h06);
    do_tick(); do_tick(); model_step(); model_step();
    bus_rd(4'h9, d); chk("R4 frozen", d, 8'h06);
    bus_wr(4'h8, 8'h00);
    tick_check("R4 counters ran");

    // R7 stop bit
    s0 = to_bcd(s);
    bus_wr(4'h9, 8'h80 | s0);
    bus_rd(4'h9, d); chk("R7 stop reads", d, 8'h80 | s0);
    do_tick(); do_tick(); do_tick();
    bus_rd(4'h9, d); chk("R7 stopped", d, 8'h80 | s0);
    bus_wr(4'h9, s0);
    tick_check("R7 restart");

    // R9 calibration storage, R12 masks, R10 flags, R1 decode
    bus_wr(4'h8, 8'h2a);
    bus_rd(4'h8, d); chk("R9 cal", d, 8'h2a);
    bus_wr(4'h8, 8'h80);
    bus_wr(4'hB, 8'hff); bus_rd(4'hB, d); chk("R12 hour mask", d, 8'h3f);
    bus_wr(4'hC, 8'hff); bus_rd(4'hC, d); chk("R12 day mask", d, 8'h07);
    bus_wr(4'hE, 8'hff); bus_rd(4'hE, d); chk("R12 month mask", d, 8'h1f);
    bus_wr(4'hA, 8'hff); bus_rd(4'hA, d); chk("R12 minute mask", d, 8'h7f);
    bus_wr(4'h3, 8'hff); bus_rd(4'h3, d); chk("R12 gap", d, 8'h00);
    bus_wr(4'h0, 8'hff); bus_rd(4'h0, d); chk("R10 flags clear", d, 8'h00);
    batt = 1'b1;
    bus_rd(4'h0, d); chk("R10 flags set", d, 8'h10);
    batt = 1'b0;
    set_time(0, 0, 12, 2, 3, 3, 33, 20);
    @(negedge clk); addr = {1'b0, PAGE[ADDR_W-6:0], 4'h8}; wr_en = 1'b1; wdata = 8'h55;
    #1 chk("R1 unselected read", rdata, 8'h00);
    @(negedge clk); wr_en = 1'b0;
    bus_rd(4'h8, d); chk("R1 write ignored", d, 8'h00);

    // random calendars and tick counts
    for (int it = 0; it < 24; it++) begin
      int nmo, nyr, n;
      nmo = $urandom_range(1, 12);
      nyr = $urandom_range(0, 99);
      set_time($urandom_range(0, 1) ? 59 : $urandom_range(0, 59),
               $urandom_range(0, 1) ? 59 : $urandom_range(0, 59),
               $urandom_range(0, 1) ? 23 : $urandom_range(0, 23),
               $urandom_range(1, 7),
               $urandom_range(0, 1) ? mlen(nmo, nyr) : $urandom_range(1, mlen(nmo, nyr)),
               nmo, nyr, $urandom_range(0, 99));
      n = $urandom_range(1, 70);
      for (int k = 0; k < n; k++) begin
        do_tick(); model_step();
      end
      read_all("R2/R3 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule